// File: doc/BRIEF.md
# DMA Channel Attribute Register Bank

This block is the software-visible register file of an eight-channel DMA controller. A processor reaches it over a plain 32-bit register bus: a 12-bit byte address, a write strobe, write data and combinational read data. It holds five per-channel control bitmaps: burst-only, request mask, channel enable, alternate-descriptor select and high priority. None of these bitmaps is ever written directly. Each one has a write-one-to-set address and a write-one-to-clear address, so software can change one channel without a read-modify-write race against other software.

It also holds the control settings and status shared by all channels. These are the master enable, three bus protection bits, the descriptor base pointer and the base of the alternate descriptors derived from it. It keeps sticky per-channel completion flags, a done mask and a bus-error flag. It turns software-request writes into one-cycle request pulses. The done mask decides two things for each channel. It decides whether that channel's done and active indications reach its peripheral. It also decides whether that channel counts toward a single combined done output.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every attribute bitmap, completion flag, done-mask bit, error flag, configuration bit and base-pointer bit is zero, and so is every output driven from them.
- R2: Attribute k (0 burst-only, 1 request mask, 2 enable, 3 alternate select, 4 high priority) has its set address at 0x018+8k and its clear address at 0x01C+8k. Writing 1 to bit c at the set address sets channel c, writing 1 at the clear address clears it, and writing 0 leaves it unchanged. Reading the set address returns the bitmap, reading the clear address returns zero, and the bitmap appears on its output port one clock after the write.
- R3: Write data bits above the channel count (bits 31:8) have no effect on any per-channel bitmap, and those bits read back as zero.
- R4: The status word at 0x000 reads 7 in bits 20:16 (channel count minus one), the master enable in bit 0, and zero everywhere else.
- R5: The configuration word at 0x004 stores the master enable in bit 0 and the protection bits in 7:5. Bit 7 drives protOut[2] (cacheable), bit 6 drives protOut[1] (bufferable) and bit 5 drives protOut[0] (privileged). All other bits read as zero.
- R6: The base word at 0x008 keeps only write bits 31:8 and reads zero in 7:0. The read-only word at 0x00C returns that base plus 0x80, and writes to it are ignored.
- R7: Completion flags at 0x504 are set by chanDoneIn and stay 1 until software writes 1 to that bit. Writing 0 leaves them unchanged. When a set and a clear reach the same bit in the same cycle, the set wins.
- R8: The done mask at 0x520 is read/write. A masked channel has periphDone and periphActive forced to 0 and its flag feeds doneAny. An unmasked channel passes its flag to periphDone and chanActiveIn to periphActive, and its flag does not feed doneAny.
- R9: A busErr pulse sets bit 0 of the error word at 0x04C. Writing 1 clears it, and writing 0 leaves it set.
- R10: A write to 0x014 drives softReq with the written channel bits for exactly the next clock cycle, after which softReq is zero. The address reads as zero.
- R11: The word at 0x010 reads the waitReqIn bitmap. Every unmapped address reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 12 | Register byte address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| busErr | input | 1 | Bus error pulse from the transfer engine |
| chanDoneIn | input | 8 | Per-channel completion pulses |
| chanActiveIn | input | 8 | Per-channel active indications |
| waitReqIn | input | 8 | Per-channel wait-on-request status |
| burstOnly | output | 8 | Burst-only bitmap |
| reqMask | output | 8 | Request mask bitmap |
| chanEn | output | 8 | Channel enable bitmap |
| altSel | output | 8 | Alternate descriptor select bitmap |
| highPrio | output | 8 | High priority bitmap |
| masterEn | output | 1 | Controller master enable |
| protOut | output | 3 | Protection bits {cacheable, bufferable, privileged} |
| softReq | output | 8 | One-cycle software request pulses |
| periphDone | output | 8 | Done flags passed to peripherals |
| periphActive | output | 8 | Active indications passed to peripherals |
| doneAny | output | 1 | Combined done |

## Verification
The bench sweeps every channel of every attribute through set, clear and zero writes. It checks all five bitmaps after each write. A decoder that swapped a set/clear pair, or that wrote one attribute through another's address, would corrupt a bitmap it was not aimed at. It drives a completion pulse and a clear write in the same cycle, which a design with clear priority would lose. It also checks that the done mask gates the peripheral outputs and the combined output in opposite senses. Further cases cover upper data bits, the alternate base arithmetic, a write to the read-only address and writes to unmapped addresses. Each of these would expose a design that stored data it should discard.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int ADDR_W   = 12;
  localparam int NUM_ATTR = 5;

  localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_BASE   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ALT    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_WAIT   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_SOFT   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_ERR    = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_DONE   = 12'h504;
  localparam logic [ADDR_W-1:0] OFF_DMASK  = 12'h520;

  // Attribute k: set word at 0x018 + 8k, clear word 4 bytes above it
  function automatic logic [ADDR_W-1:0] setOff(int k);
    return 12'h018 + ADDR_W'(8 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] clrOff(int k);
    return setOff(k) + 12'h004;
  endfunction

  typedef struct packed {
    logic [NUM_ATTR-1:0] setAttr;
    logic [NUM_ATTR-1:0] clrAttr;
    logic cfgWr;
    logic baseWr;
    logic softWr;
    logic errClr;
    logic doneClr;
    logic maskWr;
  } regStrobes_t;
endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output regStrobes_t       strb
);
  always_comb begin
    strb = '0;
    if (regWr) begin
      for (int k = 0; k < NUM_ATTR; k++) begin
        strb.setAttr[k] = (regAddr == setOff(k));
        strb.clrAttr[k] = (regAddr == clrOff(k));
      end
      strb.cfgWr   = (regAddr == OFF_CFG);
      strb.baseWr  = (regAddr == OFF_BASE);
      strb.softWr  = (regAddr == OFF_SOFT);
      strb.errClr  = (regAddr == OFF_ERR);
      strb.doneClr = (regAddr == OFF_DONE);
      strb.maskWr  = (regAddr == OFF_DMASK);
    end
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb) <= 1);
  // R2
  no_write_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |-> (strb == '0));
endmodule

// File: rtl/dma_reg_data.sv
module dma_reg_data
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  regStrobes_t                       strb,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [31:0]                       regWdata,
  output logic [31:0]                       regRdata,
  input  logic                              busErr,
  input  logic [NUM_CH-1:0]                 chanDoneIn,
  input  logic [NUM_CH-1:0]                 chanActiveIn,
  input  logic [NUM_CH-1:0]                 waitReqIn,
  output logic [NUM_ATTR-1:0][NUM_CH-1:0]   attrBits,
  output logic                              masterEn,
  output logic [2:0]                        protOut,
  output logic [NUM_CH-1:0]                 softReq,
  output logic [NUM_CH-1:0]                 periphDone,
  output logic [NUM_CH-1:0]                 periphActive,
  output logic                              doneAny
);
  localparam logic [31:0] ALT_OFS = 32'(NUM_CH * DESC_BYTES);
  localparam logic [4:0]  CNT_M1  = 5'(NUM_CH - 1);

  logic [NUM_CH-1:0] wCh;
  logic [NUM_CH-1:0] doneFlags, doneMask;
  logic              errFlag;
  logic [23:0]       basePtr;
  logic [31:0]       baseWord;

  assign wCh      = regWdata[NUM_CH-1:0];
  assign baseWord = {basePtr, 8'h00};

  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 attrBits[k] <= '0;
      else if (strb.setAttr[k])  attrBits[k] <= attrBits[k] | wCh;
      else if (strb.clrAttr[k])  attrBits[k] <= attrBits[k] & ~wCh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlags <= '0;
      doneMask  <= '0;
      errFlag   <= 1'b0;
      masterEn  <= 1'b0;
      protOut   <= '0;
      basePtr   <= '0;
      softReq   <= '0;
    end else begin
      doneFlags <= (strb.doneClr ? (doneFlags & ~wCh) : doneFlags) | chanDoneIn;
      errFlag   <= (errFlag & ~(strb.errClr & regWdata[0])) | busErr;
      softReq   <= strb.softWr ? wCh : '0;
      if (strb.maskWr) doneMask <= wCh;
      if (strb.cfgWr) begin
        masterEn <= regWdata[0];
        protOut  <= regWdata[7:5];
      end
      if (strb.baseWr) basePtr <= regWdata[31:8];
    end
  end

  assign periphDone   = doneFlags & ~doneMask;
  assign periphActive = chanActiveIn & ~doneMask;
  assign doneAny      = |(doneFlags & doneMask);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFF_STATUS: regRdata = {11'b0, CNT_M1, 15'b0, masterEn};
      OFF_CFG:    regRdata = {24'b0, protOut, 4'b0, masterEn};
      OFF_BASE:   regRdata = baseWord;
      OFF_ALT:    regRdata = baseWord + ALT_OFS;
      OFF_WAIT:   regRdata = 32'(waitReqIn);
      OFF_ERR:    regRdata = {31'b0, errFlag};
      OFF_DONE:   regRdata = 32'(doneFlags);
      OFF_DMASK:  regRdata = 32'(doneMask);
      default: begin
        for (int k = 0; k < NUM_ATTR; k++)
          if (regAddr == setOff(k)) regRdata = 32'(attrBits[k]);
      end
    endcase
  end

  // R2
  attr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setAttr == '0 && strb.clrAttr == '0) |=> $stable(attrBits));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doneClr |=> ((doneFlags & $past(doneFlags)) == $past(doneFlags)));
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> errFlag);
  // R10
  soft_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.softWr |=> (softReq == '0));
  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.baseWr |=> $stable(basePtr));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              busErr,
  input  logic [NUM_CH-1:0] chanDoneIn,
  input  logic [NUM_CH-1:0] chanActiveIn,
  input  logic [NUM_CH-1:0] waitReqIn,
  output logic [NUM_CH-1:0] burstOnly,
  output logic [NUM_CH-1:0] reqMask,
  output logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] altSel,
  output logic [NUM_CH-1:0] highPrio,
  output logic              masterEn,
  output logic [2:0]        protOut,
  output logic [NUM_CH-1:0] softReq,
  output logic [NUM_CH-1:0] periphDone,
  output logic [NUM_CH-1:0] periphActive,
  output logic              doneAny
);
  regStrobes_t                     strb;
  logic [NUM_ATTR-1:0][NUM_CH-1:0] attrBits;

  dma_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .strb(strb)
  );

  dma_reg_data #(.NUM_CH(NUM_CH), .DESC_BYTES(DESC_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busErr(busErr),
    .chanDoneIn(chanDoneIn), .chanActiveIn(chanActiveIn),
    .waitReqIn(waitReqIn), .attrBits(attrBits), .masterEn(masterEn),
    .protOut(protOut), .softReq(softReq), .periphDone(periphDone),
    .periphActive(periphActive), .doneAny(doneAny)
  );

  assign burstOnly = attrBits[0];
  assign reqMask   = attrBits[1];
  assign chanEn    = attrBits[2];
  assign altSel    = attrBits[3];
  assign highPrio  = attrBits[4];
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  logic        clk = 0, rstN = 0;
  logic [11:0] regAddr = '0;
  logic        regWr = 0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busErr = 0;
  logic [7:0]  chanDoneIn = '0, chanActiveIn = '0, waitReqIn = '0;
  logic [7:0]  burstOnly, reqMask, chanEn, altSel, highPrio, softReq;
  logic [7:0]  periphDone, periphActive;
  logic        masterEn, doneAny;
  logic [2:0]  protOut;
  int checks = 0, errors = 0;
  logic [7:0]  model [5];

  dma_chan_regs uut (.*);

  always #4 clk = ~clk;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  function automatic logic [7:0] attrPort(int k);
    case (k)
      0: return burstOnly;
      1: return reqMask;
      2: return chanEn;
      3: return altSel;
      default: return highPrio;
    endcase
  endfunction

  task automatic checkAttrs(string req);
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      rd(12'h018 + 12'(8 * k), d);
      chk(req, d, {24'b0, model[k]});
      chk(req, {24'b0, attrPort(k)}, {24'b0, model[k]});
    end
  endtask

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 5; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checkAttrs("R1");
    chk("R1", {masterEn, protOut, softReq, periphDone, periphActive, doneAny}, '0);
    rd(12'h504, d); chk("R1", d, 0);
    rd(12'h008, d); chk("R1", d, 0);
    rd(12'h04C, d); chk("R1", d, 0);
    // R4 status
    rd(12'h000, d); chk("R4", d, 32'h0007_0000);
    // R5 config
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R5", d, 32'hE1);
    chk("R5", {masterEn, protOut}, 4'hF);
    rd(12'h000, d); chk("R4", d, 32'h0007_0001);
    wr(12'h004, 32'h0000_0020);
    chk("R5", {masterEn, protOut}, 4'b0001);
    wr(12'h004, 32'h0000_0080);
    chk("R5", {28'b0, masterEn, protOut}, 32'b0100);
    // R2 per-channel set sweep, then clears, then zero writes
    for (int k = 0; k < 5; k++) begin
      for (int ch = 0; ch < 8; ch++) begin
        logic [7:0] p;
        p = 8'(1 << ch) | 8'(k * 37);
        wr(12'h018 + 12'(8 * k), {24'b0, p});
        model[k] = model[k] | p;
        checkAttrs("R2 set");
        rd(12'h01C + 12'(8 * k), d); chk("R2 clear reads zero", d, 0);
      end
      for (int ch = 0; ch < 8; ch += 3) begin
        logic [7:0] q;
        q = 8'(3 << ch);
        wr(12'h01C + 12'(8 * k), {24'b0, q});
        model[k] = model[k] & ~q;
        checkAttrs("R2 clear");
      end
      wr(12'h018 + 12'(8 * k), 32'h0);
      wr(12'h01C + 12'(8 * k), 32'h0);
      checkAttrs("R2 zero write");
    end
    // R3 upper data bits
    for (int k = 0; k < 5; k++) begin
      wr(12'h018 + 12'(8 * k), 32'hFFFF_FF00);
      wr(12'h01C + 12'(8 * k), 32'hFFFF_FF00);
    end
    checkAttrs("R3");
    // R6 base pointer and alternate base
    wr(12'h008, 32'h1234_5678);
    rd(12'h008, d); chk("R6", d, 32'h1234_5600);
    rd(12'h00C, d); chk("R6", d, 32'h1234_5680);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R6", d, 32'h1234_5600);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h00C, d); chk("R6", d, 32'hFFFF_FF80);
    // R7 sticky done flags
    @(negedge clk); chanDoneIn = 8'h81;
    @(negedge clk); chanDoneIn = 8'h00;
    rd(12'h504, d); chk("R7", d, 32'h81);
    wr(12'h504, 32'h0);
    rd(12'h504, d); chk("R7", d, 32'h81);
    wr(12'h504, 32'h1);
    rd(12'h504, d); chk("R7", d, 32'h80);
    @(negedge clk); regAddr = 12'h504; regWdata = 32'h80; regWr = 1; chanDoneIn = 8'h80;
    @(negedge clk); regWr = 0; chanDoneIn = 8'h00;
    rd(12'h504, d); chk("R7 set wins", d, 32'h80);
    // R8 done mask
    chanActiveIn = 8'hFF;
    #1;
    chk("R8", {doneAny, periphDone, periphActive}, {1'b0, 8'h80, 8'hFF});
    wr(12'h520, 32'h80);
    rd(12'h520, d); chk("R8", d, 32'h80);
    chk("R8", {doneAny, periphDone, periphActive}, {1'b1, 8'h00, 8'h7F});
    wr(12'h520, 32'h01);
    chk("R8", {doneAny, periphDone, periphActive}, {1'b0, 8'h80, 8'hFE});
    // R9 bus error flag
    @(negedge clk); busErr = 1;
    @(negedge clk); busErr = 0;
    rd(12'h04C, d); chk("R9", d, 1);
    wr(12'h04C, 32'h0);
    rd(12'h04C, d); chk("R9", d, 1);
    wr(12'h04C, 32'h1);
    rd(12'h04C, d); chk("R9", d, 0);
    // R10 software request pulse
    @(negedge clk); regAddr = 12'h014; regWdata = 32'hA5; regWr = 1;
    #1; chk("R10 before edge", {24'b0, softReq}, 0);
    @(negedge clk); regWr = 0;
    chk("R10 pulse", {24'b0, softReq}, 32'hA5);
    @(negedge clk);
    chk("R10 one cycle", {24'b0, softReq}, 0);
    rd(12'h014, d); chk("R10 reads zero", d, 0);
    // R11 wait status and unmapped addresses
    waitReqIn = 8'h3C;
    rd(12'h010, d); chk("R11", d, 32'h3C);
    rd(12'h040, d); chk("R11", d, 0);
    rd(12'h500, d); chk("R11", d, 0);
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h500, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    checkAttrs("R11");
    rd(12'h504, d); chk("R11", d, 32'h80);
    rd(12'h520, d); chk("R11", d, 32'h01);
    rd(12'h004, d); chk("R11", d, 32'h80);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule